// File: doc/BRIEF.md
# Timeslot Switch Interrupt Aggregator

This block gathers the interrupt events of a telecom timeslot switch and drives one interrupt request line to a host CPU. There are four sources: backplane clock failure, frame boundary, an internal master PLL error, and a summary bus-error flag. The summary flag is the OR of three groups of error status lines, 4, 3 and 4 bits wide. A rising edge on any source sets a sticky status bit. All four status bits sit in one register byte, so a single host read shows whether this device raised the request and which source did.

The host reaches three byte-wide registers through a plain select/write/address interface with a combinational read path. The status register clears by writing ones to it. A mask register enables each source on its own. A 3-bit control field holds a global enable, the output polarity, and a choice between a level output and a one-cycle pulse output. Event inputs and host signals are synchronous to `clk`. Every pin is plain control or status, so the block has no stream handshake.

Top module: `tsi_irq_agg`

## Requirements
- R1: After reset the status (address 0), mask (address 1) and control (address 2) registers read 0, and `irq_out` is high (deasserted, active low).
- R2: A rising edge on `ev_clkfail`, `ev_frame` or `ev_pllerr` sets status bit 0, 1 or 2 at the next clock edge. An input held high sets its bit only once, so a bit cleared while its input stays high stays clear.
- R3: Status bit 3 is set at the next clock edge on a rising edge of the OR of `err_grp_a`, `err_grp_b` and `err_grp_c`. Any single bit of any group triggers it.
- R4: Status bits stay set until the host writes address 0 with a 1 in that bit position. Bits written as 0 are unaffected. Status read bits 7:4 are always 0.
- R5: If a clear of a status bit and a new rising edge on the same source happen in the same cycle, the bit remains set.
- R6: Mask register bits 3:0 enable the matching sources (1 = enabled). A masked source still latches and reads back in status, but it does not assert the request.
- R7: Control bit 0 is the global enable, bit 1 the polarity (0 = asserted low, 1 = asserted high) and bit 2 the mode (0 = level, 1 = pulse). With bit 0 at 0 the output stays at its deasserted level.
- R8: In level mode the output is asserted from one clock edge after an enabled, unmasked status bit is set, and deasserts one clock edge after no such bit remains.
- R9: In pulse mode the output is asserted for exactly one cycle, one clock edge after the pending condition rises. It then returns to deasserted while the condition holds.
- R10: With control bit 1 set, the output idles low and is driven high when asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_clkfail | input | 1 | Backplane clock failure event |
| ev_frame | input | 1 | Frame boundary event |
| ev_pllerr | input | 1 | Internal master PLL error event |
| err_grp_a | input | 4 | Bus error group A |
| err_grp_b | input | 3 | Bus error group B |
| err_grp_c | input | 4 | Bus error group C |
| host_sel | input | 1 | Host register access select |
| host_wr | input | 1 | Host write strobe (with select) |
| host_addr | input | 2 | Register address: 0 status, 1 mask, 2 control |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational from address) |
| irq_out | output | 1 | Interrupt request, polarity set by control bit 1 |

## Verification
A source edge that is present before a rising clock edge shows in status right after that edge. The request output follows one edge later, because the output stage is registered. A host write takes effect at the edge where it is presented, and its effect on the output lands one edge after that. Each scenario task drives inputs at the falling edge and samples at later falling edges. It counts each of these register stages, so every check reads the output in the exact cycle where a change is due, and also in the cycle just before it.

// File: rtl/tsi_irq_pkg.sv
package tsi_irq_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_CLKFAIL = 0;
  localparam int SRC_FRAME   = 1;
  localparam int SRC_PLLERR  = 2;
  localparam int SRC_BUSERR  = 3;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MASK   = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;

  localparam int CTRL_W = 3;

  typedef struct packed {
    logic pulse;   // bit 2
    logic pol_hi;  // bit 1
    logic en;      // bit 0
  } ctrl_t;
endpackage

// File: rtl/tsi_src_latch.sv
module tsi_src_latch #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] clr,
  output logic [N-1:0] status
);
  logic [N-1:0] raw_d;

  for (genvar gi = 0; gi < N; gi++) begin : g_src
    logic rise;
    assign rise = raw[gi] & ~raw_d[gi];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        raw_d[gi]  <= 1'b0;
        status[gi] <= 1'b0;
      end else begin
        raw_d[gi]  <= raw[gi];
        status[gi] <= (status[gi] & ~clr[gi]) | rise;
      end
    end

    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (raw[gi] && !raw_d[gi]) |=> status[gi]); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (status[gi] && !clr[gi]) |=> status[gi]); // R4
  end
endmodule

// File: rtl/tsi_host_regs.sv
module tsi_host_regs
  import tsi_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_sel,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [DATA_W-1:0]  host_wdata,
  input  logic [NUM_SRC-1:0] status,
  output logic [DATA_W-1:0]  host_rdata,
  output logic [NUM_SRC-1:0] clr,
  output logic [NUM_SRC-1:0] mask,
  output ctrl_t              ctrl
);
  logic wr_en;
  logic unused_wdata_hi;

  assign wr_en = host_sel & host_wr;
  assign unused_wdata_hi = ^host_wdata[DATA_W-1:NUM_SRC];
  assign clr = (wr_en && host_addr == ADDR_W'(ADDR_STATUS)) ?
               host_wdata[NUM_SRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      ctrl <= '0;
    end else if (wr_en) begin
      if (host_addr == ADDR_W'(ADDR_MASK)) mask <= host_wdata[NUM_SRC-1:0];
      if (host_addr == ADDR_W'(ADDR_CTRL)) ctrl <= ctrl_t'(host_wdata[CTRL_W-1:0]);
    end
  end

  always_comb begin
    host_rdata = '0;
    if (host_sel) begin
      unique case (host_addr)
        ADDR_W'(ADDR_STATUS): host_rdata = DATA_W'(status);
        ADDR_W'(ADDR_MASK):   host_rdata = DATA_W'(mask);
        ADDR_W'(ADDR_CTRL):   host_rdata = DATA_W'(ctrl);
        default:              host_rdata = '0;
      endcase
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && host_addr == ADDR_W'(ADDR_MASK)) |=> $stable(mask)); // R6
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && host_addr == ADDR_W'(ADDR_CTRL)) |=> $stable(ctrl)); // R7
endmodule

// File: rtl/tsi_irq_drive.sv
module tsi_irq_drive
  import tsi_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] status,
  input  logic [NUM_SRC-1:0] mask,
  input  ctrl_t              ctrl,
  output logic               irq_out
);
  logic pend, pend_d, act;

  assign pend = ctrl.en & (|(status & mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_d <= 1'b0;
      act    <= 1'b0;
    end else begin
      pend_d <= pend;
      act    <= ctrl.pulse ? (pend & ~pend_d) : pend;
    end
  end

  assign irq_out = ctrl.pol_hi ? act : ~act;

  AST_DIS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> !act); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.pulse && act && $stable(ctrl)) |=> !act); // R9
endmodule

// File: rtl/tsi_irq_agg.sv
module tsi_irq_agg
  import tsi_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int GRPA_W = 4,
  parameter int GRPB_W = 3,
  parameter int GRPC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_clkfail,
  input  logic              ev_frame,
  input  logic              ev_pllerr,
  input  logic [GRPA_W-1:0] err_grp_a,
  input  logic [GRPB_W-1:0] err_grp_b,
  input  logic [GRPC_W-1:0] err_grp_c,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq_out
);
  logic [NUM_SRC-1:0] raw, clr, status, mask;
  ctrl_t ctrl;

  always_comb begin
    raw = '0;
    raw[SRC_CLKFAIL] = ev_clkfail;
    raw[SRC_FRAME]   = ev_frame;
    raw[SRC_PLLERR]  = ev_pllerr;
    raw[SRC_BUSERR]  = (|err_grp_a) | (|err_grp_b) | (|err_grp_c);
  end

  tsi_src_latch #(.N(NUM_SRC)) u_latch (
    .clk(clk), .rst_n(rst_n), .raw(raw), .clr(clr), .status(status)
  );

  tsi_host_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .status(status),
    .host_rdata(host_rdata), .clr(clr), .mask(mask), .ctrl(ctrl)
  );

  tsi_irq_drive u_drive (
    .clk(clk), .rst_n(rst_n), .status(status), .mask(mask), .ctrl(ctrl),
    .irq_out(irq_out)
  );

  AST_BUSERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(raw[SRC_BUSERR]) && $past(rst_n)) |=> status[SRC_BUSERR]); // R3
endmodule

// File: tb/tb_tsi_irq_agg.sv
module tb_tsi_irq_agg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_clkfail = 0, ev_frame = 0, ev_pllerr = 0;
  logic [3:0] err_grp_a = 0;
  logic [2:0] err_grp_b = 0;
  logic [3:0] err_grp_c = 0;
  logic host_sel = 0, host_wr = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic irq_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tsi_irq_agg dut (
    .clk(clk), .rst_n(rst_n), .ev_clkfail(ev_clkfail), .ev_frame(ev_frame),
    .ev_pllerr(ev_pllerr), .err_grp_a(err_grp_a), .err_grp_b(err_grp_b),
    .err_grp_c(err_grp_c), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    host_sel = 1; host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0; host_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_sel = 1; host_wr = 0; host_addr = a;
    #1 d = host_rdata;
    host_sel = 0;
  endtask

  task automatic set_ev(input int s, input logic v);
    case (s)
      0: ev_clkfail = v;
      1: ev_frame = v;
      default: ev_pllerr = v;
    endcase
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(0, d); chk("R1 status", d, 8'h00);
    rd(1, d); chk("R1 mask", d, 8'h00);
    rd(2, d); chk("R1 ctrl", d, 8'h00);
    chk("R1 irq_out", {7'd0, irq_out}, 8'h01);
  endtask

  task automatic t_events();
    logic [7:0] d;
    for (int s = 0; s < 3; s++) begin
      set_ev(s, 1); tick(1);
      rd(0, d); chk("R2 edge sets bit", d, 8'h01 << s);
      wr(0, 8'h00);
      rd(0, d); chk("R4 write zero keeps bit", d, 8'h01 << s);
      wr(0, 8'h01 << s);
      rd(0, d); chk("R2 held level no reset", d, 8'h00);
      tick(2);
      rd(0, d); chk("R2 held level sets once", d, 8'h00);
      set_ev(s, 0); tick(1);
    end
  endtask

  task automatic t_buserr();
    logic [7:0] d;
    for (int b = 0; b < 11; b++) begin
      if (b < 4) err_grp_a[b] = 1;
      else if (b < 7) err_grp_b[b-4] = 1;
      else err_grp_c[b-7] = 1;
      tick(1);
      rd(0, d); chk("R3 group bit sets bit3", d, 8'h08);
      err_grp_a = 0; err_grp_b = 0; err_grp_c = 0;
      wr(0, 8'hF8);
      rd(0, d); chk("R4 w1c bit3, hi bits zero", d, 8'h00);
    end
  endtask

  task automatic t_collide();
    logic [7:0] d;
    ev_frame = 1; tick(1); ev_frame = 0; tick(1);
    ev_frame = 1; wr(0, 8'h02);
    rd(0, d); chk("R5 clear with new edge keeps bit", d, 8'h02);
    ev_frame = 0;
    wr(0, 8'h02);
    rd(0, d); chk("R5 later clear works", d, 8'h00);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(1, 8'h02); wr(2, 8'h01);
    ev_clkfail = 1; tick(1); ev_clkfail = 0;
    rd(0, d); chk("R6 masked source latched", d, 8'h01);
    tick(2);
    chk("R6 masked source no irq", {7'd0, irq_out}, 8'h01);
    wr(0, 8'h01);
    ev_frame = 1; tick(1); ev_frame = 0;
    chk("R8 not yet asserted", {7'd0, irq_out}, 8'h01);
    tick(1);
    chk("R8 asserted one edge later", {7'd0, irq_out}, 8'h00);
    tick(3);
    chk("R8 level held", {7'd0, irq_out}, 8'h00);
    wr(0, 8'h02);
    chk("R8 still asserted after clear edge", {7'd0, irq_out}, 8'h00);
    tick(1);
    chk("R8 deasserted", {7'd0, irq_out}, 8'h01);
    wr(1, 8'h0F); wr(2, 8'h00);
    ev_pllerr = 1; tick(1); ev_pllerr = 0; tick(3);
    chk("R7 disabled stays idle", {7'd0, irq_out}, 8'h01);
    wr(0, 8'h0F); tick(1);
  endtask

  task automatic t_pulse();
    wr(2, 8'h05);
    ev_pllerr = 1; tick(1); ev_pllerr = 0;
    chk("R9 before pulse", {7'd0, irq_out}, 8'h01);
    tick(1);
    chk("R9 pulse asserted", {7'd0, irq_out}, 8'h00);
    tick(1);
    chk("R9 pulse one cycle", {7'd0, irq_out}, 8'h01);
    tick(3);
    chk("R9 no repeat while pending", {7'd0, irq_out}, 8'h01);
    wr(0, 8'h04); tick(1);
  endtask

  task automatic t_polarity();
    wr(2, 8'h02); tick(2);
    chk("R10 idle low", {7'd0, irq_out}, 8'h00);
    wr(2, 8'h03);
    ev_frame = 1; tick(1); ev_frame = 0; tick(1);
    chk("R10 asserted high", {7'd0, irq_out}, 8'h01);
    wr(0, 8'h02); tick(1);
    chk("R10 deasserted low", {7'd0, irq_out}, 8'h00);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_events();
    t_buserr();
    t_collide();
    t_level();
    t_pulse();
    t_polarity();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule